// File: doc/BRIEF.md
# SMBus Configuration Register Slave

This block puts a bank of fifteen 8-bit configuration registers on a two-wire SMBus. The system clock oversamples the bus clock and data lines. The block decodes START and STOP conditions and serves four transfer types: indexed byte write, indexed byte read, counted block write and counted block read. The data line is driven only through an open-drain pull-down enable.

Every register is visible at all times on a flat parallel output bus, so the surrounding logic reads its settings directly. A one-cycle strobe per register marks each accepted write. Two fields cannot be written. One register carries five strap inputs, which are captured while reset is held. Another register carries a fixed identity code. The command byte chooses the transfer type. With its top bit set, the transfer reaches a single register whose offset is given by the low seven bits. With its top bit clear, the transfer is a block transfer that always starts at register 0, and a block read begins with a byte that gives the register count.

Top module: `cfgbus_slave`

## Requirements
- R1: While reset is high and after it falls, the registers hold these values: reg0 0x00, reg1 0xFF, reg2 0x7F, reg3 0xEB, reg4 0x00, reg7 0x00, reg8 0x01, regs 9 to 14 0x00. The pull-down enable is low.
- R2: The block acknowledges only the address byte 0xD2 for a write or 0xD3 for a read (7-bit address 0x69, R/W in the LSB, acknowledge means data held low in the ninth clock). Any other address gets no acknowledge, and the rest of that transfer changes nothing.
- R3: A byte write is address 0xD2, then a command with bit 7 = 1 and the offset in bits 6:0, then one data byte. It updates that register. Every write to offsets 0 to 14 pulses exactly that register's bit of the strobe bus for one cycle.
- R4: A byte read is address 0xD2, a command with bit 7 = 1 and the offset, a repeated START, address 0xD3, then one byte from the slave, NACK and STOP. The byte returned is the register at that offset.
- R5: A block write is address 0xD2, command 0x00, a count byte, then data bytes. The data bytes land at offsets 0, 1, 2 and so on in order. A STOP after any whole byte keeps the bytes already received and leaves the later registers unchanged.
- R6: A block read is address 0xD2, command 0x00, a repeated START, then address 0xD3. The slave sends 15 first and then the registers from offset 0 upward for as long as the master acknowledges.
- R7: Every byte is sent MSB first. The slave acknowledges each command, count and written data byte after a matching address.
- R8: Reg5 bits 7:3 hold the strap inputs captured during reset, ignore writes and do not follow later strap changes. Bits 2:0 are writable and reset to 001.
- R9: Reg6 reads as 0x18 at all times: identity bits 7:4 = 0001, vendor bits 3:0 = 1000. Writes have no effect on it.
- R10: Offsets 15 to 127 read as 0x00. Writes to them change no register and pulse no strobe.
- R11: A STOP or a new START in the middle of a byte abandons the transfer without writing anything. The next transfer works normally.
- R12: The pull-down enable rises only while the synchronized clock is low, and it is low whenever the bus is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset; strap capture window |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| strap_in | input | 5 | Strap levels captured while reset is high |
| sda_oe | output | 1 | Pull data line low when 1 |
| reg_flat | output | 120 | All registers, reg i at bits 8i+7:8i |
| wr_stb | output | 15 | One-cycle pulse per register on an accepted write |

## Verification
If the bit counter or the phase tracking is corrupted, the fault shows in the ninth clock of the very next byte. An acknowledge is missing or appears in the wrong slot, or the read data is shifted by a bit, and the master sees this on the data line at once. A wrong pointer appears as a value on the parallel bus at the wrong offset, or as a strobe on the wrong bit one cycle after the last data bit is sampled. Masking errors on the strap or identity fields show up on the parallel bus immediately after the write that should have had no effect.

// File: rtl/cfgbus_pkg.sv
`timescale 1ns/1ps
package cfgbus_pkg;

    localparam int BYTE_W    = 8;
    localparam int STRAP_REG = 5;
    localparam int ID_REG    = 6;
    localparam logic [BYTE_W-1:0] ID_FIXED = 8'h18;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACKW,
        ST_ACKD,
        ST_TX,
        ST_MACK
    } cb_state_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_CMD,
        PH_CNT,
        PH_DATA
    } cb_phase_e;

    typedef struct packed {
        logic              en;
        logic [6:0]        addr;
        logic [BYTE_W-1:0] data;
    } cb_wr_t;

    // Reset content of the writable bits of each register
    function automatic logic [BYTE_W-1:0] reg_default(input int idx);
        case (idx)
            1:       return 8'hFF;
            2:       return 8'h7F;
            3:       return 8'hEB;
            5:       return 8'h01;
            8:       return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    // Bits that a bus write may change
    function automatic logic [BYTE_W-1:0] reg_wmask(input int idx);
        case (idx)
            STRAP_REG: return 8'h07;
            ID_REG:    return 8'h00;
            default:   return 8'hFF;
        endcase
    endfunction

    // Constant bits overlaid on the stored value (strap field handled apart)
    function automatic logic [BYTE_W-1:0] reg_fixed(input int idx);
        if (idx == ID_REG) return ID_FIXED;
        return 8'h00;
    endfunction

endpackage

// File: rtl/cfgbus_sync.sv
`timescale 1ns/1ps
module cfgbus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_d;
    logic              sda_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_in};
            sda_q <= {sda_q[STAGES-2:0], sda_in};
            scl_d <= scl_q[STAGES-1];
            sda_d <= sda_q[STAGES-1];
        end
    end

    assign scl_s     = scl_q[STAGES-1];
    assign sda_s     = sda_q[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/cfgbus_engine.sv
`timescale 1ns/1ps
module cfgbus_engine
    import cfgbus_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int          NUM_REGS = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic [6:0]        rd_addr,
    output cb_wr_t            wr,
    output logic              sda_oe
);
    localparam logic [BYTE_W-1:0] COUNT_BYTE = 8'(NUM_REGS);

    cb_state_e         state;
    cb_phase_e         phase;
    logic [3:0]        bcnt;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] txs;
    logic              ack_pend;
    logic              tx_next;
    logic              blk;
    logic              more;
    logic [6:0]        ptr;
    logic [BYTE_W-1:0] byte_in;
    logic [BYTE_W-1:0] first_tx;

    assign byte_in  = {shreg[6:0], sda_s};
    assign first_tx = blk ? COUNT_BYTE : rd_data;
    assign rd_addr  = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            phase    <= PH_ADDR;
            bcnt     <= '0;
            shreg    <= '0;
            txs      <= '0;
            ack_pend <= 1'b0;
            tx_next  <= 1'b0;
            blk      <= 1'b0;
            more     <= 1'b0;
            ptr      <= '0;
            sda_oe   <= 1'b0;
            wr       <= '0;
        end else begin
            wr.en <= 1'b0;
            if (start_det) begin
                state  <= ST_RX;
                phase  <= PH_ADDR;
                bcnt   <= '0;
                sda_oe <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_RX: begin
                        if (scl_rise) begin
                            shreg <= byte_in;
                            bcnt  <= bcnt + 4'd1;
                            if (bcnt == 4'd7) begin
                                state <= ST_ACKW;
                                case (phase)
                                    PH_ADDR: begin
                                        ack_pend <= (byte_in[7:1] == DEV_ADDR);
                                        tx_next  <= byte_in[0];
                                        phase    <= byte_in[0] ? PH_DATA : PH_CMD;
                                    end
                                    PH_CMD: begin
                                        ack_pend <= 1'b1;
                                        tx_next  <= 1'b0;
                                        blk      <= ~byte_in[7];
                                        ptr      <= byte_in[7] ? byte_in[6:0] : 7'd0;
                                        phase    <= byte_in[7] ? PH_DATA : PH_CNT;
                                    end
                                    PH_CNT: begin
                                        ack_pend <= 1'b1;
                                        tx_next  <= 1'b0;
                                        phase    <= PH_DATA;
                                    end
                                    default: begin
                                        ack_pend <= 1'b1;
                                        tx_next  <= 1'b0;
                                        wr.en    <= 1'b1;
                                        wr.addr  <= ptr;
                                        wr.data  <= byte_in;
                                        ptr      <= ptr + 7'd1;
                                    end
                                endcase
                            end
                        end
                    end
                    ST_ACKW: begin
                        if (scl_fall) begin
                            if (ack_pend) begin
                                sda_oe <= 1'b1;
                                state  <= ST_ACKD;
                            end else begin
                                state  <= ST_IDLE;
                            end
                        end
                    end
                    ST_ACKD: begin
                        if (scl_fall) begin
                            bcnt <= '0;
                            if (tx_next) begin
                                state  <= ST_TX;
                                txs    <= first_tx;
                                sda_oe <= ~first_tx[7];
                                if (!blk) ptr <= ptr + 7'd1;
                            end else begin
                                state  <= ST_RX;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (scl_rise) bcnt <= bcnt + 4'd1;
                        if (scl_fall) begin
                            if (bcnt == 4'd8) begin
                                sda_oe <= 1'b0;
                                state  <= ST_MACK;
                            end else begin
                                txs    <= {txs[6:0], 1'b0};
                                sda_oe <= ~txs[6];
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_rise) more <= ~sda_s;
                        if (scl_fall) begin
                            if (more) begin
                                txs    <= rd_data;
                                sda_oe <= ~rd_data[7];
                                ptr    <= ptr + 7'd1;
                                bcnt   <= '0;
                                state  <= ST_TX;
                            end else begin
                                state  <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst) $rose(sda_oe) |-> !scl_s); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) (state == ST_IDLE) |-> !sda_oe); // R12
    AST_WR_AFTER_RISE: assert property (@(posedge clk) disable iff (rst) wr.en |-> $past(scl_rise)); // R3
    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        start_det |=> (state == ST_RX && bcnt == 4'd0 && phase == PH_ADDR && !sda_oe)); // R11

endmodule

// File: rtl/cfgbus_regbank.sv
`timescale 1ns/1ps
module cfgbus_regbank
    import cfgbus_pkg::*;
#(
    parameter int NUM_REGS = 15,
    parameter int STRAP_W  = 5
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [STRAP_W-1:0]         strap_in,
    input  cb_wr_t                     wr,
    input  logic [6:0]                 rd_addr,
    output logic [BYTE_W-1:0]          rd_data,
    output logic [NUM_REGS*BYTE_W-1:0] reg_flat,
    output logic [NUM_REGS-1:0]        wr_stb
);
    localparam int STRAP_LSB = BYTE_W - STRAP_W;

    logic [STRAP_W-1:0] strap_q;
    logic [BYTE_W-1:0]  store [NUM_REGS];
    logic [BYTE_W-1:0]  view  [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) strap_q <= strap_in;
    end

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [BYTE_W-1:0] WMASK = reg_wmask(i);
        localparam logic [BYTE_W-1:0] RVAL  = reg_default(i);
        logic hit;
        assign hit = wr.en && (wr.addr == 7'(i));
        always_ff @(posedge clk) begin
            if (rst) begin
                store[i]  <= RVAL & WMASK;
                wr_stb[i] <= 1'b0;
            end else begin
                wr_stb[i] <= hit;
                if (hit) store[i] <= wr.data & WMASK;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (i == STRAP_REG)
                view[i] = store[i] | {strap_q, {STRAP_LSB{1'b0}}};
            else
                view[i] = store[i] | reg_fixed(i);
            reg_flat[i*BYTE_W +: BYTE_W] = view[i];
            if (rd_addr == 7'(i)) rd_data = view[i];
        end
    end

    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(wr_stb)); // R3
    AST_STRAP_FIXED: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(view[STRAP_REG][BYTE_W-1:STRAP_LSB])); // R8
    AST_OOR_NO_STB: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.addr >= 7'(NUM_REGS)) |=> (wr_stb == '0)); // R10

endmodule

// File: rtl/cfgbus_slave.sv
`timescale 1ns/1ps
module cfgbus_slave
    import cfgbus_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NUM_REGS    = 15,
    parameter int         SYNC_STAGES = 2,
    parameter int         STRAP_W     = 5
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       scl_in,
    input  logic                       sda_in,
    input  logic [STRAP_W-1:0]         strap_in,
    output logic                       sda_oe,
    output logic [NUM_REGS*BYTE_W-1:0] reg_flat,
    output logic [NUM_REGS-1:0]        wr_stb
);
    logic              scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [6:0]        rd_addr;
    logic [BYTE_W-1:0] rd_data;
    cb_wr_t            wr;

    cfgbus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cfgbus_engine #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .wr        (wr),
        .sda_oe    (sda_oe)
    );

    cfgbus_regbank #(.NUM_REGS(NUM_REGS), .STRAP_W(STRAP_W)) u_regbank (
        .clk      (clk),
        .rst      (rst),
        .strap_in (strap_in),
        .wr       (wr),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .reg_flat (reg_flat),
        .wr_stb   (wr_stb)
    );

endmodule

// File: tb/cfgbus_slave_tb.sv
`timescale 1ns/1ps
module cfgbus_slave_tb;
    localparam int NR = 15;
    localparam int H  = 12;
    localparam logic [4:0] STRAP_RST = 5'b10110;
    // {offset, data} byte-write / byte-read vectors
    localparam logic [15:0] VEC [10] = '{
        16'h00A5, 16'h043C, 16'h05FF, 16'h0600, 16'h0881,
        16'h0E5A, 16'h1477, 16'h7F11, 16'h0AC3, 16'h05F2
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic [4:0] strap = STRAP_RST;
    logic sda_oe;
    logic [NR*8-1:0] reg_flat;
    logic [NR-1:0] wr_stb;
    logic sda_line;
    int checks = 0;
    int errors = 0;
    int stb_cnt [NR];
    bit done = 1'b0;
    logic [7:0] mdl [NR];

    assign sda_line = m_sda & ~sda_oe;
    always #2.5 clk = ~clk;

    cfgbus_slave u_dut (
        .clk      (clk),
        .rst      (rst),
        .scl_in   (m_scl),
        .sda_in   (sda_line),
        .strap_in (strap),
        .sda_oe   (sda_oe),
        .reg_flat (reg_flat),
        .wr_stb   (wr_stb)
    );

    always @(posedge clk) begin
        for (int i = 0; i < NR; i++) if (!rst && wr_stb[i]) stb_cnt[i]++;
    end

    function automatic int stb_total();
        int s = 0;
        for (int i = 0; i < NR; i++) s += stb_cnt[i];
        return s;
    endfunction

    function automatic logic [7:0] expect_val(input int off, input logic [7:0] d);
        if (off == 5) return {STRAP_RST, d[2:0]};
        if (off == 6) return 8'h18;
        return d;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
        end
    endtask

    task automatic hw();  repeat (H) @(negedge clk); endtask
    task automatic gap(); repeat (3) @(negedge clk); endtask

    task automatic bus_start();
        m_sda = 1'b1; m_scl = 1'b1; hw();
        m_sda = 1'b0; hw();
        m_scl = 1'b0; gap();
    endtask

    task automatic bus_rstart();
        m_sda = 1'b1; hw();
        m_scl = 1'b1; hw();
        m_sda = 1'b0; hw();
        m_scl = 1'b0; gap();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; hw();
        m_scl = 1'b1; hw();
        m_sda = 1'b1; hw();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            m_sda = b[i]; hw();
            m_scl = 1'b1; hw();
            m_scl = 1'b0; gap();
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        m_sda = 1'b1; hw();
        m_scl = 1'b1; hw();
        ack = ~sda_line;
        m_scl = 1'b0; gap();
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hw();
            m_scl = 1'b1; hw();
            b[i] = sda_line;
            m_scl = 1'b0; gap();
        end
        m_sda = give_ack ? 1'b0 : 1'b1; hw();
        m_scl = 1'b1; hw();
        m_scl = 1'b0; gap();
        m_sda = 1'b1;
    endtask

    task automatic byte_write(input logic [6:0] off, input logic [7:0] d);
        logic a0, a1, a2;
        bus_start();
        send_byte(8'hD2, a0);
        send_byte({1'b1, off}, a1);
        send_byte(d, a2);
        bus_stop();
        check("R2 address ack", a0, 1);
        check("R7 cmd/data ack", {a1, a2}, 2'b11);
    endtask

    task automatic byte_read(input logic [6:0] off, output logic [7:0] d);
        logic a0, a1, a2;
        bus_start();
        send_byte(8'hD2, a0);
        send_byte({1'b1, off}, a1);
        bus_rstart();
        send_byte(8'hD3, a2);
        recv_byte(1'b0, d);
        bus_stop();
        check("R2 read address ack", {a0, a1, a2}, 3'b111);
    endtask

    initial begin
        logic ack, a1, a2, a3;
        logic [7:0] rb;
        int tot;
        mdl = '{8'h00, 8'hFF, 8'h7F, 8'hEB, 8'h00, 8'hB1, 8'h18, 8'h00,
                8'h01, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        repeat (10) @(negedge clk);
        // R1 / R8 / R9: values held during reset
        check("R1 reset reg3", reg_flat[3*8 +: 8], 8'hEB);
        rst = 1'b0;
        @(negedge clk);
        strap = 5'b01001;
        repeat (4) @(negedge clk);
        for (int i = 0; i < NR; i++) begin
            check(i == 5 ? "R8 strap reset" : (i == 6 ? "R9 identity reset" : "R1 reset value"),
                  reg_flat[i*8 +: 8], mdl[i]);
        end
        check("R12 idle enable low", sda_oe, 0);

        // R2: foreign address ignored
        tot = stb_total();
        bus_start();
        send_byte(8'hA4, ack);
        send_byte(8'h80, a1);
        send_byte(8'h55, a2);
        bus_stop();
        check("R2 foreign address nack", ack, 0);
        check("R2 foreign write no effect", reg_flat[7:0], mdl[0]);
        check("R2 foreign write no strobe", stb_total(), tot);

        // Vector walk: byte write then byte read
        for (int v = 0; v < 10; v++) begin
            int off;
            logic [7:0] d, e;
            int before_tot, before_one;
            off = int'(VEC[v][15:8]);
            d = VEC[v][7:0];
            before_tot = stb_total();
            before_one = (off < NR) ? stb_cnt[off] : 0;
            byte_write(7'(off), d);
            e = (off < NR) ? expect_val(off, d) : 8'h00;
            if (off < NR) begin
                mdl[off] = e;
                check(off == 5 ? "R8 strap write masked" : (off == 6 ? "R9 identity write ignored" : "R3 byte write"),
                      reg_flat[off*8 +: 8], e);
                check("R3 strobe pulse", {stb_cnt[off] - before_one, stb_total() - before_tot}, {32'd1, 32'd1});
            end else begin
                check("R10 out-of-range no strobe", stb_total(), before_tot);
            end
            byte_read(7'(off), rb);
            check(off < NR ? "R4 byte read" : "R10 out-of-range read", rb, e);
        end
        for (int i = 0; i < NR; i++) check("R10 registers untouched", reg_flat[i*8 +: 8], mdl[i]);

        // R7: MSB-first ordering
        byte_write(7'd7, 8'h01);
        mdl[7] = 8'h01;
        byte_read(7'd7, rb);
        check("R7 MSB first", rb, 8'h01);

        // R5: full block write
        bus_start();
        send_byte(8'hD2, ack);
        send_byte(8'h00, a1);
        send_byte(8'h03, a2);
        check("R7 block acks", {ack, a1, a2}, 3'b111);
        send_byte(8'h11, a1);
        send_byte(8'h22, a2);
        send_byte(8'h33, a3);
        bus_stop();
        check("R7 block data acks", {a1, a2, a3}, 3'b111);
        mdl[0] = 8'h11; mdl[1] = 8'h22; mdl[2] = 8'h33;
        check("R5 block write", reg_flat[23:0], 24'h332211);
        check("R5 block write stops at count", reg_flat[31:24], mdl[3]);

        // R5: early stop in block write
        bus_start();
        send_byte(8'hD2, ack);
        send_byte(8'h00, a1);
        send_byte(8'h05, a2);
        send_byte(8'h44, a1);
        send_byte(8'h66, a2);
        bus_stop();
        mdl[0] = 8'h44; mdl[1] = 8'h66;
        check("R5 early stop", reg_flat[23:0], 24'h336644);

        // R6: block read
        bus_start();
        send_byte(8'hD2, ack);
        send_byte(8'h00, a1);
        bus_rstart();
        send_byte(8'hD3, a2);
        check("R6 block read acks", {ack, a1, a2}, 3'b111);
        recv_byte(1'b1, rb);
        check("R6 count byte", rb, 8'd15);
        for (int i = 0; i < NR; i++) begin
            recv_byte(i != NR - 1, rb);
            check("R6 block data", rb, mdl[i]);
        end
        bus_stop();
        check("R12 enable low after read", sda_oe, 0);

        // R10: high offset read
        byte_read(7'd30, rb);
        check("R10 read offset 30", rb, 8'h00);

        // R11: STOP in the middle of a data byte
        tot = stb_total();
        bus_start();
        send_byte(8'hD2, ack);
        send_byte(8'h83, a1);
        send_bits(8'h00, 4);
        bus_stop();
        check("R11 stop abort", reg_flat[3*8 +: 8], mdl[3]);
        check("R11 stop abort no strobe", stb_total(), tot);

        // R11: repeated START in the middle of a data byte
        bus_start();
        send_byte(8'hD2, ack);
        send_byte(8'h81, a1);
        send_bits(8'h00, 3);
        bus_rstart();
        send_byte(8'hD2, ack);
        send_byte(8'h82, a1);
        send_byte(8'h5E, a2);
        bus_stop();
        mdl[2] = 8'h5E;
        check("R11 restart abort keeps reg1", reg_flat[15:8], mdl[1]);
        check("R11 transfer after restart", reg_flat[23:16], 8'h5E);
        check("R12 idle enable low", sda_oe, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule